// File: doc/BRIEF.md
# Rename Throttle

This block decides, once per cycle, how many instructions at the head of the rename queue may leave it. Its inputs are the number of instructions waiting, the free entry counts reported by the reorder buffer, the issue queue and the load and store queues, the free physical register count for each register class, and one descriptor per slot. A descriptor carries load, store, atomic and squashed flags and a destination register count for each class. Its outputs are the number of slots to pop, how many of those were actually renamed, a block-this-cycle flag and a one-hot flag naming the structure that ran out.

Instructions that have been renamed but are not yet counted by the downstream structures are tracked in three in-flight counters: all instructions, loads, and stores including atomics. These counters are subtracted from the reported free counts before any decision is made. They shrink by the dispatch counts the downstream stage reports back. Every output is registered, so a decision appears one clock after the inputs that caused it.

Top module: `rename_throttle`

## Requirements
- R1: While reset is high and in the first cycle after it, every output is zero.
- R2: When no instruction is waiting (avail_cnt of 0), take_cnt and ren_cnt are 0, stall_blk is 0 and full_evt is 0.
- R3: The structure limit is the smaller of free_rob minus inflight_insts and free_iq minus inflight_insts. If it is zero or below while instructions wait, nothing is taken, stall_blk is 1, and full_evt sets bit 1 (issue queue) when the issue-queue side is strictly smaller and otherwise bit 0 (reorder buffer).
- R4: If the structure limit is positive but below avail_cnt, no more than the limit is taken and stall_blk is 1. full_evt names the limiting structure as in R3 unless R12 applies.
- R5: take_cnt never exceeds the WIDTH parameter, even when avail_cnt is larger. Slots are considered only up to the smaller of WIDTH and avail_cnt.
- R6: A load slot proceeds only while free_lq minus inflight_loads, less the loads already renamed earlier in the same group, is above zero. Otherwise that slot and every later slot are not taken, stall_blk is 1 and full_evt bit 2 is set.
- R7: A store or atomic slot proceeds only while free_sq minus inflight_stores, less the stores and atomics renamed earlier in the group, is above zero. Otherwise the group stops there, stall_blk is 1 and full_evt bit 3 is set.
- R8: A slot whose destination count for any class exceeds the registers of that class still left after earlier slots in the group stops the group. That slot is not taken, stall_blk is 1 and full_evt bit 4 is set.
- R9: A squashed slot that passes the queue checks of R6 and R7 is popped: it counts in take_cnt but not in ren_cnt, and it uses no queue entries and no registers.
- R10: take_cnt, ren_cnt, stall_blk and full_evt reflect the inputs present before the previous rising clock edge, and hold between edges.
- R11: Each cycle inflight_insts grows by the renamed count and drops by disp_iq. inflight_loads grows by the renamed loads and drops by disp_lq. inflight_stores grows by the renamed stores and atomics and drops by disp_sq.
- R12: At most one bit of full_evt is set. A stop from R6, R7 or R8 takes precedence over the reorder buffer or issue queue limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| avail_cnt | input | AW | Number of instructions waiting at the queue head |
| free_rob | input | CNT_W | Free reorder buffer entries reported downstream |
| free_iq | input | CNT_W | Free issue queue entries reported downstream |
| free_lq | input | CNT_W | Free load queue entries reported downstream |
| free_sq | input | CNT_W | Free store queue entries reported downstream |
| free_regs | input | NCLS*CNT_W | Free physical registers, class c at bits c*CNT_W |
| slot_load | input | WIDTH | Slot i is a load |
| slot_store | input | WIDTH | Slot i is a store |
| slot_atomic | input | WIDTH | Slot i is an atomic |
| slot_squash | input | WIDTH | Slot i has been squashed |
| slot_ndst | input | WIDTH*NCLS*DST_W | Destination count of slot i, class c at bits (i*NCLS+c)*DST_W |
| disp_iq | input | CNT_W | Instructions dispatched downstream last cycle |
| disp_lq | input | CNT_W | Loads dispatched into the load queue |
| disp_sq | input | CNT_W | Stores dispatched into the store queue |
| take_cnt | output | AW | Slots popped this cycle |
| ren_cnt | output | AW | Slots renamed this cycle |
| stall_blk | output | 1 | Rename blocks this cycle |
| full_evt | output | 5 | One-hot exhausted structure: 0 ROB, 1 IQ, 2 LQ, 3 SQ, 4 registers |
| inflight_insts | output | CNT_W | Renamed instructions not yet counted downstream |
| inflight_loads | output | CNT_W | Renamed loads not yet counted downstream |
| inflight_stores | output | CNT_W | Renamed stores and atomics not yet counted downstream |

## Verification
The in-flight checks assume that each dispatch count never exceeds the counter it decrements. They also assume that avail_cnt and the free counts fit their widths, so the counters neither wrap nor go negative. The stimulus picks every disp_* value from zero up to the reference model's current count. It derives the free counts from the model's in-flight values and clips them to the counter range, so effective free counts go negative only through the signed subtraction the design handles. Directed cycles build each stop condition at a known slot. Random cycles mix the flags and sizes so that stops on each structure and squashed slots also appear together.

// File: rtl/rt_pkg.sv
package rt_pkg;
  localparam int NUM_EV = 5;

  typedef enum int {
    EV_ROB = 0,
    EV_IQ  = 1,
    EV_LQ  = 2,
    EV_SQ  = 3,
    EV_REG = 4
  } ev_idx_e;

  localparam int NUM_CTR = 3;
endpackage

// File: rtl/rt_counter.sv
module rt_counter #(
  parameter int CNT_W = 6,
  parameter int INC_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [INC_W-1:0] inc,
  input  logic [CNT_W-1:0] dec,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + CNT_W'(inc) - dec;
  end
endmodule

// File: rtl/rt_limit.sv
module rt_limit #(
  parameter int CNT_W = 6,
  parameter int WIDTH = 4,
  parameter int AW    = 3
) (
  input  logic [CNT_W-1:0] free_rob,
  input  logic [CNT_W-1:0] free_iq,
  input  logic [CNT_W-1:0] inflight,
  input  logic [AW-1:0]    avail,
  output logic [AW-1:0]    cap,
  output logic             zero_blk,
  output logic             partial_blk,
  output logic             iq_side
);
  localparam int SW = CNT_W + 2;
  localparam logic signed [SW-1:0] WID_S  = SW'(WIDTH);
  localparam logic signed [SW-1:0] ZERO_S = '0;

  logic signed [SW-1:0] rob_s, iq_s, lim_s, avail_s, m_s;
  logic has_work;

  always_comb begin
    rob_s    = $signed({2'b00, free_rob}) - $signed({2'b00, inflight});
    iq_s     = $signed({2'b00, free_iq})  - $signed({2'b00, inflight});
    iq_side  = iq_s < rob_s;
    lim_s    = iq_side ? iq_s : rob_s;
    avail_s  = $signed(SW'(avail));
    m_s      = lim_s;
    if (avail_s < m_s) m_s = avail_s;
    if (WID_S < m_s)   m_s = WID_S;
    has_work    = avail != '0;
    zero_blk    = has_work && (lim_s <= ZERO_S);
    partial_blk = has_work && (lim_s > ZERO_S) && (lim_s < avail_s);
    cap         = (lim_s <= ZERO_S) ? '0 : AW'(m_s);
  end
endmodule

// File: rtl/rt_scan.sv
module rt_scan
  import rt_pkg::*;
#(
  parameter int WIDTH = 4,
  parameter int NCLS  = 2,
  parameter int DST_W = 2,
  parameter int CNT_W = 6,
  parameter int AW    = 3
) (
  input  logic [AW-1:0]               cap,
  input  logic signed [CNT_W+1:0]     eff_lq,
  input  logic signed [CNT_W+1:0]     eff_sq,
  input  logic [NCLS*CNT_W-1:0]       free_regs,
  input  logic [WIDTH-1:0]            slot_load,
  input  logic [WIDTH-1:0]            slot_store,
  input  logic [WIDTH-1:0]            slot_atomic,
  input  logic [WIDTH-1:0]            slot_squash,
  input  logic [WIDTH*NCLS*DST_W-1:0] slot_ndst,
  output logic [AW-1:0]               take_n,
  output logic [AW-1:0]               ren_n,
  output logic [AW-1:0]               ld_n,
  output logic [AW-1:0]               st_n,
  output logic                        stop,
  output logic [NUM_EV-1:0]           stop_evt
);
  localparam int SW = CNT_W + 2;
  localparam logic signed [SW-1:0] ZERO_S = '0;
  localparam logic signed [SW-1:0] ONE_S  = SW'(1);

  logic signed [SW-1:0] lq_left, sq_left;
  logic [CNT_W-1:0]     reg_left [NCLS];
  logic                 is_st, short_regs;

  always_comb begin
    lq_left  = eff_lq;
    sq_left  = eff_sq;
    for (int c = 0; c < NCLS; c++) reg_left[c] = free_regs[c*CNT_W +: CNT_W];
    take_n   = '0;
    ren_n    = '0;
    ld_n     = '0;
    st_n     = '0;
    stop     = 1'b0;
    stop_evt = '0;
    is_st    = 1'b0;
    short_regs = 1'b0;
    for (int i = 0; i < WIDTH; i++) begin
      is_st      = slot_store[i] | slot_atomic[i];
      short_regs = 1'b0;
      for (int c = 0; c < NCLS; c++)
        if (CNT_W'(slot_ndst[(i*NCLS+c)*DST_W +: DST_W]) > reg_left[c]) short_regs = 1'b1;
      if (!stop && (AW'(i) < cap)) begin
        if (slot_load[i] && (lq_left <= ZERO_S)) begin
          stop = 1'b1;
          stop_evt[EV_LQ] = 1'b1;
        end else if (is_st && (sq_left <= ZERO_S)) begin
          stop = 1'b1;
          stop_evt[EV_SQ] = 1'b1;
        end else if (slot_squash[i]) begin
          take_n = take_n + AW'(1);
        end else if (short_regs) begin
          stop = 1'b1;
          stop_evt[EV_REG] = 1'b1;
        end else begin
          take_n = take_n + AW'(1);
          ren_n  = ren_n + AW'(1);
          if (slot_load[i]) begin
            lq_left = lq_left - ONE_S;
            ld_n    = ld_n + AW'(1);
          end
          if (is_st) begin
            sq_left = sq_left - ONE_S;
            st_n    = st_n + AW'(1);
          end
          for (int c = 0; c < NCLS; c++)
            reg_left[c] = reg_left[c] - CNT_W'(slot_ndst[(i*NCLS+c)*DST_W +: DST_W]);
        end
      end
    end
  end
endmodule

// File: rtl/rename_throttle.sv
module rename_throttle
  import rt_pkg::*;
#(
  parameter int WIDTH = 4,
  parameter int NCLS  = 2,
  parameter int DST_W = 2,
  parameter int CNT_W = 6,
  parameter int AW    = $clog2(WIDTH + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [AW-1:0]               avail_cnt,
  input  logic [CNT_W-1:0]            free_rob,
  input  logic [CNT_W-1:0]            free_iq,
  input  logic [CNT_W-1:0]            free_lq,
  input  logic [CNT_W-1:0]            free_sq,
  input  logic [NCLS*CNT_W-1:0]       free_regs,
  input  logic [WIDTH-1:0]            slot_load,
  input  logic [WIDTH-1:0]            slot_store,
  input  logic [WIDTH-1:0]            slot_atomic,
  input  logic [WIDTH-1:0]            slot_squash,
  input  logic [WIDTH*NCLS*DST_W-1:0] slot_ndst,
  input  logic [CNT_W-1:0]            disp_iq,
  input  logic [CNT_W-1:0]            disp_lq,
  input  logic [CNT_W-1:0]            disp_sq,
  output logic [AW-1:0]               take_cnt,
  output logic [AW-1:0]               ren_cnt,
  output logic                        stall_blk,
  output logic [NUM_EV-1:0]           full_evt,
  output logic [CNT_W-1:0]            inflight_insts,
  output logic [CNT_W-1:0]            inflight_loads,
  output logic [CNT_W-1:0]            inflight_stores
);
  localparam int SW = CNT_W + 2;

  logic [AW-1:0]        cap;
  logic                 zero_blk, partial_blk, iq_side;
  logic signed [SW-1:0] eff_lq, eff_sq;
  logic [AW-1:0]        take_c, ren_c, ld_c, st_c;
  logic                 stop_c;
  logic [NUM_EV-1:0]    stop_evt_c, evt_c;
  logic                 blk_c;

  logic [AW-1:0]    inc_a [NUM_CTR];
  logic [CNT_W-1:0] dec_a [NUM_CTR];
  logic [CNT_W-1:0] cnt_a [NUM_CTR];

  rt_limit #(.CNT_W(CNT_W), .WIDTH(WIDTH), .AW(AW)) u_limit (
    .free_rob    (free_rob),
    .free_iq     (free_iq),
    .inflight    (cnt_a[0]),
    .avail       (avail_cnt),
    .cap         (cap),
    .zero_blk    (zero_blk),
    .partial_blk (partial_blk),
    .iq_side     (iq_side)
  );

  assign eff_lq = $signed({2'b00, free_lq}) - $signed({2'b00, cnt_a[1]});
  assign eff_sq = $signed({2'b00, free_sq}) - $signed({2'b00, cnt_a[2]});

  rt_scan #(.WIDTH(WIDTH), .NCLS(NCLS), .DST_W(DST_W), .CNT_W(CNT_W), .AW(AW)) u_scan (
    .cap         (cap),
    .eff_lq      (eff_lq),
    .eff_sq      (eff_sq),
    .free_regs   (free_regs),
    .slot_load   (slot_load),
    .slot_store  (slot_store),
    .slot_atomic (slot_atomic),
    .slot_squash (slot_squash),
    .slot_ndst   (slot_ndst),
    .take_n      (take_c),
    .ren_n       (ren_c),
    .ld_n        (ld_c),
    .st_n        (st_c),
    .stop        (stop_c),
    .stop_evt    (stop_evt_c)
  );

  always_comb begin
    blk_c = zero_blk | partial_blk | stop_c;
    evt_c = '0;
    if (stop_c)                      evt_c = stop_evt_c;
    else if (zero_blk | partial_blk) evt_c[iq_side ? EV_IQ : EV_ROB] = 1'b1;
  end

  assign inc_a[0] = ren_c;
  assign inc_a[1] = ld_c;
  assign inc_a[2] = st_c;
  assign dec_a[0] = disp_iq;
  assign dec_a[1] = disp_lq;
  assign dec_a[2] = disp_sq;

  for (genvar k = 0; k < NUM_CTR; k++) begin : g_ctr
    rt_counter #(.CNT_W(CNT_W), .INC_W(AW)) u_ctr (
      .clk (clk),
      .rst (rst),
      .inc (inc_a[k]),
      .dec (dec_a[k]),
      .cnt (cnt_a[k])
    );
  end

  assign inflight_insts  = cnt_a[0];
  assign inflight_loads  = cnt_a[1];
  assign inflight_stores = cnt_a[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      take_cnt  <= '0;
      ren_cnt   <= '0;
      stall_blk <= 1'b0;
      full_evt  <= '0;
    end else begin
      take_cnt  <= take_c;
      ren_cnt   <= ren_c;
      stall_blk <= blk_c;
      full_evt  <= evt_c;
    end
  end
endmodule

// File: rtl/rt_throttle_chk.sv
module rt_throttle_chk #(
  parameter int WIDTH = 4,
  parameter int CNT_W = 6,
  parameter int AW    = 3,
  parameter int NEV   = 5
) (
  input logic             clk,
  input logic             rst,
  input logic [AW-1:0]    avail_cnt,
  input logic [CNT_W-1:0] free_rob,
  input logic [CNT_W-1:0] free_iq,
  input logic [CNT_W-1:0] disp_iq,
  input logic [AW-1:0]    take_cnt,
  input logic [AW-1:0]    ren_cnt,
  input logic             stall_blk,
  input logic [NEV-1:0]   full_evt,
  input logic [CNT_W-1:0] inflight_insts
);
  logic signed [CNT_W+1:0] rob_room, iq_room;
  assign rob_room = $signed({2'b00, free_rob}) - $signed({2'b00, inflight_insts});
  assign iq_room  = $signed({2'b00, free_iq})  - $signed({2'b00, inflight_insts});

  assert_take_cap_R5: assert property (@(posedge clk) disable iff (rst)
    take_cnt <= AW'(WIDTH));

  assert_ren_le_take_R9: assert property (@(posedge clk) disable iff (rst)
    ren_cnt <= take_cnt);

  assert_evt_onehot_R12: assert property (@(posedge clk) disable iff (rst)
    $onehot0(full_evt));

  assert_evt_blocks_R4: assert property (@(posedge clk) disable iff (rst)
    (full_evt != '0) |-> stall_blk);

  assert_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (avail_cnt == '0) |=> (take_cnt == '0 && !stall_blk && full_evt == '0));

  assert_zero_room_R3: assert property (@(posedge clk) disable iff (rst)
    (avail_cnt != '0 && (rob_room <= 0 || iq_room <= 0)) |=> (take_cnt == '0 && stall_blk));

  assert_take_le_avail_R10: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (take_cnt <= $past(avail_cnt)));

  assert_inflight_R11: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (inflight_insts == $past(inflight_insts) + CNT_W'(ren_cnt) - $past(disp_iq)));
endmodule

bind rename_throttle rt_throttle_chk #(
  .WIDTH(WIDTH), .CNT_W(CNT_W), .AW(AW), .NEV(rt_pkg::NUM_EV)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .avail_cnt      (avail_cnt),
  .free_rob       (free_rob),
  .free_iq        (free_iq),
  .disp_iq        (disp_iq),
  .take_cnt       (take_cnt),
  .ren_cnt        (ren_cnt),
  .stall_blk      (stall_blk),
  .full_evt       (full_evt),
  .inflight_insts (inflight_insts)
);

// File: tb/tb_rename_throttle.sv
`timescale 1ns/1ps
module tb_rename_throttle;
  localparam int W  = 4;
  localparam int NC = 2;
  localparam int DW = 2;
  localparam int CW = 6;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [AW-1:0]       avail_cnt;
  logic [CW-1:0]       free_rob, free_iq, free_lq, free_sq;
  logic [NC*CW-1:0]    free_regs;
  logic [W-1:0]        slot_load, slot_store, slot_atomic, slot_squash;
  logic [W*NC*DW-1:0]  slot_ndst;
  logic [CW-1:0]       disp_iq, disp_lq, disp_sq;
  logic [AW-1:0]       take_cnt, ren_cnt;
  logic                stall_blk;
  logic [4:0]          full_evt;
  logic [CW-1:0]       inflight_insts, inflight_loads, inflight_stores;

  rename_throttle #(.WIDTH(W), .NCLS(NC), .DST_W(DW), .CNT_W(CW)) dut (.*);

  int m_ins, m_ld, m_st;
  int e_take, e_ren, e_blk, e_evt;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic clear_in();
    avail_cnt = '0; free_rob = 6'd40; free_iq = 6'd40; free_lq = 6'd30; free_sq = 6'd30;
    free_regs = {6'd30, 6'd30};
    slot_load = '0; slot_store = '0; slot_atomic = '0; slot_squash = '0; slot_ndst = '0;
    disp_iq = '0; disp_lq = '0; disp_sq = '0;
  endtask

  function automatic int clip(int v);
    return (v < 0) ? 0 : (v > 63) ? 63 : v;
  endfunction

  function automatic int nd(int i, int c);
    return int'(slot_ndst[(i*NC+c)*DW +: DW]);
  endfunction

  task automatic set_nd(int i, int c, int v);
    slot_ndst[(i*NC+c)*DW +: DW] = DW'(v);
  endtask

  task automatic model();
    int rob_r, iq_r, lim, src, cap, lq, sq, ld, st;
    int rg [NC];
    bit stop, bad;
    e_take = 0; e_ren = 0; e_blk = 0; e_evt = 0; ld = 0; st = 0;
    rob_r = int'(free_rob) - m_ins;
    iq_r  = int'(free_iq) - m_ins;
    src   = (iq_r < rob_r) ? 1 : 0;
    lim   = (iq_r < rob_r) ? iq_r : rob_r;
    if (avail_cnt != 0) begin
      if (lim <= 0) begin
        e_blk = 1; e_evt = 1 << src;
      end else begin
        cap = lim;
        if (int'(avail_cnt) < cap) cap = int'(avail_cnt);
        if (W < cap) cap = W;
        if (lim < int'(avail_cnt)) begin e_blk = 1; e_evt = 1 << src; end
        lq = int'(free_lq) - m_ld;
        sq = int'(free_sq) - m_st;
        for (int c = 0; c < NC; c++) rg[c] = int'(free_regs[c*CW +: CW]);
        stop = 0;
        for (int i = 0; i < cap && !stop; i++) begin
          bad = 0;
          for (int c = 0; c < NC; c++) if (nd(i, c) > rg[c]) bad = 1;
          if (slot_load[i] && lq <= 0) begin stop = 1; e_evt = 4; end
          else if ((slot_store[i] || slot_atomic[i]) && sq <= 0) begin stop = 1; e_evt = 8; end
          else if (slot_squash[i]) e_take++;
          else if (bad) begin stop = 1; e_evt = 16; end
          else begin
            e_take++; e_ren++;
            if (slot_load[i]) begin lq--; ld++; end
            if (slot_store[i] || slot_atomic[i]) begin sq--; st++; end
            for (int c = 0; c < NC; c++) rg[c] -= nd(i, c);
          end
        end
        if (stop) e_blk = 1;
      end
    end
    m_ins = m_ins + e_ren - int'(disp_iq);
    m_ld  = m_ld + ld - int'(disp_lq);
    m_st  = m_st + st - int'(disp_sq);
  endtask

  task automatic step(string tag);
    model();
    @(posedge clk);
    @(negedge clk);
    chk(tag, "take_cnt", int'(take_cnt), e_take);
    chk(tag, "ren_cnt", int'(ren_cnt), e_ren);
    chk(tag, "stall_blk", int'(stall_blk), e_blk);
    chk(tag, "full_evt", int'(full_evt), e_evt);
    chk("R11", "inflight_insts", int'(inflight_insts), m_ins);
    chk("R11", "inflight_loads", int'(inflight_loads), m_ld);
    chk("R11", "inflight_stores", int'(inflight_stores), m_st);
  endtask

  initial begin
    m_ins = 0; m_ld = 0; m_st = 0;
    clear_in();
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1", "take_cnt", int'(take_cnt), 0);
    chk("R1", "full_evt", int'(full_evt), 0);
    chk("R1", "inflight_insts", int'(inflight_insts), 0);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R1", "stall_blk", int'(stall_blk), 0);
    chk("R1", "ren_cnt", int'(ren_cnt), 0);

    // R2: nothing waiting
    clear_in();
    step("R2");

    // R10: plain group, result one edge later
    clear_in(); avail_cnt = 3'd4;
    for (int i = 0; i < W; i++) set_nd(i, 0, 1);
    #1 chk("R10", "take_before_edge", int'(take_cnt), 0);
    step("R10");
    clear_in();
    #1 chk("R10", "take_hold", int'(take_cnt), 4);

    // R4: reorder buffer allows two
    free_rob = CW'(clip(m_ins + 2)); avail_cnt = 3'd4;
    step("R4");

    // R3: issue queue exhausted, then tie goes to reorder buffer
    clear_in(); free_iq = CW'(clip(m_ins)); avail_cnt = 3'd2;
    step("R3");
    clear_in(); free_iq = CW'(clip(m_ins)); free_rob = CW'(clip(m_ins)); avail_cnt = 3'd1;
    step("R3");

    // R11: drain in-flight counts
    clear_in(); disp_iq = CW'(m_ins); disp_lq = CW'(m_ld); disp_sq = CW'(m_st);
    step("R11");

    // R6: one load entry left, two loads
    clear_in(); avail_cnt = 3'd3; free_lq = CW'(clip(m_ld + 1));
    slot_load = 4'b0011;
    step("R6");

    // R7: one store entry left, store then atomic
    clear_in(); avail_cnt = 3'd3; free_sq = CW'(clip(m_st + 1));
    slot_store = 4'b0001; slot_atomic = 4'b0010;
    step("R7");

    // R8: class 1 registers run out at slot 1
    clear_in(); avail_cnt = 3'd3; free_regs = {6'd2, 6'd30};
    set_nd(0, 1, 2); set_nd(1, 1, 1);
    step("R8");

    // R9: squashed slot uses no registers
    clear_in(); avail_cnt = 3'd2; free_regs = {6'd0, 6'd1};
    slot_squash = 4'b0001; set_nd(0, 0, 3); set_nd(0, 1, 3); set_nd(1, 0, 1);
    step("R9");
    // R9: squashed load still meets the load queue check
    clear_in(); avail_cnt = 3'd2; free_lq = CW'(clip(m_ld));
    slot_squash = 4'b0001; slot_load = 4'b0001;
    step("R9");

    // R5: more waiting than the width
    clear_in(); avail_cnt = 3'd7;
    step("R5");

    // R12: limit of three plus a load stop
    clear_in(); free_rob = CW'(clip(m_ins + 3)); avail_cnt = 3'd4;
    free_lq = CW'(clip(m_ld + 1)); slot_load = 4'b0011;
    step("R12");

    // R11: drain again
    clear_in(); disp_iq = CW'(m_ins); disp_lq = CW'(m_ld); disp_sq = CW'(m_st);
    step("R11");

    // random mix
    for (int n = 0; n < 400; n++) begin
      clear_in();
      avail_cnt = AW'($urandom_range(0, 6));
      free_rob  = CW'(clip(m_ins + int'($urandom_range(0, 8)) - 2));
      free_iq   = CW'(clip(m_ins + int'($urandom_range(0, 8)) - 2));
      free_lq   = CW'(clip(m_ld + int'($urandom_range(0, 4)) - 1));
      free_sq   = CW'(clip(m_st + int'($urandom_range(0, 4)) - 1));
      free_regs = {CW'($urandom_range(0, 6)), CW'($urandom_range(0, 6))};
      for (int i = 0; i < W; i++) begin
        slot_load[i]   = ($urandom_range(0, 3) == 0);
        slot_store[i]  = ($urandom_range(0, 3) == 0);
        slot_atomic[i] = ($urandom_range(0, 7) == 0);
        slot_squash[i] = ($urandom_range(0, 5) == 0);
        for (int c = 0; c < NC; c++) set_nd(i, c, int'($urandom_range(0, 2)));
      end
      disp_iq = CW'($urandom_range(0, m_ins));
      disp_lq = CW'($urandom_range(0, m_ld));
      disp_sq = CW'($urandom_range(0, m_st));
      step("R4");
    end

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule